// File: doc/BRIEF.md
# Associative Address Translator with Access Checks

This block turns a 32-bit virtual address into a physical address for a data read, a data write or an instruction fetch. Two fixed windows of the address space skip translation. Every other address goes through a fully associative table of page descriptors, or is truncated to 29 bits when translation is switched off. The table search covers every entry at once. Each entry may describe a 1 KB, 4 KB, 64 KB or 1 MB page.

A hit is then checked against the entry's permissions, its address-space tag and its modified state. A failed check returns a numeric fault code instead of an address. A small round-robin counter moves forward on each table search, so that a refill agent outside the block can use it to pick a victim. For faults that a refill could resolve, the block keeps the faulting address and its page number.

Entries are loaded one at a time through a write port. A request strobe starts a lookup. The response (address, fault code and cacheable flag) appears in registers one clock later.

Top module: `xl_translate`

## Requirements
- R1: The size code of an entry selects its page size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. An entry covers the page-aligned range that contains `vpn<<10`.
- R2: An entry can match only when its valid bit is set. It must also be shared, or carry a tag equal to `cur_asid`, or be looked up while tag checking is off.
- R3: Tag checking is off exactly when `single_virt` and `priv` are both 1.
- R4: When two or more entries match, the fault is 0x140. When no entry matches, the fault is 0x060 for a write (kind 1) and 0x040 for a read (kind 0) or a fetch (kind 2).
- R5: With `priv` = 0 and protection bit 1 clear, a read or fetch gives 0x0A0 and a write gives 0x0C0. A write to an entry whose protection bit 0 is clear also gives 0x0C0, whatever the privilege.
- R6: A write that passes the protection checks, to an entry whose dirty bit is clear, gives 0x080.
- R7: On a successful hit, the physical address is the page-aligned `ppn<<10` merged with the page-offset bits of the virtual address. `rsp_cacheable` then equals the entry's cacheable bit. In every other case `rsp_cacheable` is 0.
- R8: Addresses 0x80000000 to 0xBFFFFFFF bypass the table and lose their top 3 bits. Addresses from 0xE0000000 upward bypass the table unchanged. With `priv` = 0, both windows give 0x100 for a write and 0x0E0 for a read or fetch, except for 0xE0000000 to 0xE3FFFFFF.
- R9: With `xlate_en` = 0, any address outside the bypass windows maps to its low 29 bits, with no fault.
- R10: `repl_ctr` steps only on requests that search the table. It wraps to 0 when the stepped value would exceed a nonzero `rc_limit`, or would exceed 63. It resets to 0.
- R11: Every fault loads `fault_addr` with the request address. Every fault except 0x140 also loads `fault_vpn` with address bits 31:10.
- R12: The response registers update one clock after `req_valid` and hold while no request arrives. A fault code of 0 means success. `rsp_paddr` is 0 whenever the fault code is nonzero. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| priv | input | 1 | Privileged access |
| cur_asid | input | 8 | Current address-space tag |
| xlate_en | input | 1 | Translation enable |
| single_virt | input | 1 | Single-virtual-space mode |
| rc_limit | input | 6 | Wrap boundary for the replacement counter (0 = none) |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 22 | Virtual page number |
| wr_ppn | input | 19 | Physical page number |
| wr_asid | input | 8 | Entry tag |
| wr_valid | input | 1 | Entry valid |
| wr_shared | input | 1 | Entry ignores tag |
| wr_dirty | input | 1 | Entry already modified |
| wr_cache | input | 1 | Entry cacheable |
| wr_prot | input | 2 | Bit 1 user access, bit 0 writable |
| wr_size | input | 2 | Page size code |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 12 | Fault code, 0 on success |
| rsp_cacheable | output | 1 | Hit entry cacheable |
| repl_ctr | output | 6 | Replacement counter |
| fault_addr | output | 32 | Last faulting address |
| fault_vpn | output | 22 | Page number of last refillable fault |

## Verification
The hardest case to reach is the multiple-hit fault. It needs two valid entries whose ranges overlap for the current tag. Plain random loading almost never produces this, so the stimulus places a 1 MB page and a 1 KB page inside it and probes the small page's range. The same sequence shows that `fault_vpn` keeps its earlier value when this fault is taken. Counter wrapping at 63 is reached by a long run of searching requests with no limit. The random phase draws addresses near the loaded pages, so that range edges and permission faults come up often.

// File: rtl/xl_pkg.sv
package xl_pkg;

  localparam int VA_W   = 32;
  localparam int PG_SH  = 10;
  localparam int VPN_W  = VA_W - PG_SH;
  localparam int PA_W   = 29;
  localparam int PPN_W  = PA_W - PG_SH;
  localparam int ASID_W = 8;
  localparam int FC_W   = 12;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  localparam logic [FC_W-1:0] F_NONE    = 12'h000;
  localparam logic [FC_W-1:0] F_MISS_RD = 12'h040;
  localparam logic [FC_W-1:0] F_MISS_WR = 12'h060;
  localparam logic [FC_W-1:0] F_INIT_WR = 12'h080;
  localparam logic [FC_W-1:0] F_PROT_RD = 12'h0A0;
  localparam logic [FC_W-1:0] F_PROT_WR = 12'h0C0;
  localparam logic [FC_W-1:0] F_AERR_RD = 12'h0E0;
  localparam logic [FC_W-1:0] F_AERR_WR = 12'h100;
  localparam logic [FC_W-1:0] F_MULTI   = 12'h140;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic              sh;
    logic              dirty;
    logic              cach;
    logic [1:0]        prot;
    logic [1:0]        sz;
  } ent_t;

  // Fields handed back from the table on a hit.
  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             dirty;
    logic             cach;
    logic [1:0]       prot;
    logic [1:0]       sz;
  } hit_t;

  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    page_mask = 32'hFFFF_FC00;
      2'd1:    page_mask = 32'hFFFF_F000;
      2'd2:    page_mask = 32'hFFFF_0000;
      default: page_mask = 32'hFFF0_0000;
    endcase
  endfunction

endpackage

// File: rtl/xl_cam.sv
module xl_cam
  import xl_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  ent_t                       wr_ent,
  input  logic                       wr_valid,
  input  logic [VA_W-1:0]            lk_addr,
  input  logic [ASID_W-1:0]          lk_asid,
  input  logic                       asid_chk,
  output logic                       hit_any,
  output logic                       hit_multi,
  output hit_t                       hit_fld
);

  localparam int IW    = $clog2(ENTRIES);
  localparam int HIT_W = $bits(hit_t);

  logic [ENTRIES-1:0]            hitv;
  logic [ENTRIES-1:0][HIT_W-1:0] contrib;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic            v_q;
    ent_t            e_q;
    logic [VA_W-1:0] msk;
    logic            sel;

    assign sel = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= 1'b0;
      else if (sel) v_q <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (sel) e_q <= wr_ent;
    end

    assign msk     = page_mask(e_q.sz);
    assign hitv[g] = v_q
                   && (e_q.sh || !asid_chk || (e_q.asid == lk_asid))
                   && ((lk_addr & msk) == ({e_q.vpn, {PG_SH{1'b0}}} & msk));
    assign contrib[g] = hitv[g] ? HIT_W'({e_q.ppn, e_q.dirty, e_q.cach, e_q.prot, e_q.sz})
                                : '0;
  end

  always_comb begin
    logic [HIT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < ENTRIES; i++) acc = acc | contrib[i];
    hit_fld = hit_t'(acc);
  end

  assign hit_any   = |hitv;
  assign hit_multi = |(hitv & (hitv - 1'b1));

endmodule

// File: rtl/xl_region.sv
module xl_region
  import xl_pkg::*;
(
  input  logic [VA_W-1:0] addr,
  input  logic            priv,
  output logic            bypass,
  output logic            aerr,
  output logic [VA_W-1:0] byp_addr
);

  logic low_win;
  logic top_win;
  logic open_win;

  assign low_win  = (addr[31:30] == 2'b10);
  assign top_win  = (addr[31:29] == 3'b111);
  assign open_win = top_win && (addr[28:26] == 3'b000);

  assign bypass   = low_win || top_win;
  assign aerr     = bypass && !priv && !open_win;
  assign byp_addr = low_win ? {3'b000, addr[28:0]} : addr;

endmodule

// File: rtl/xl_rr_ctr.sv
module xl_rr_ctr #(
  parameter int ENTRIES = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  input  logic [$clog2(ENTRIES)-1:0] limit,
  output logic [$clog2(ENTRIES)-1:0] cnt
);

  localparam int IW = $clog2(ENTRIES);

  logic [IW:0]   wide;
  logic [IW-1:0] cnt_nxt;

  always_comb begin
    wide = {1'b0, cnt} + 1'b1;
    if (((limit != '0) && (wide > {1'b0, limit})) || (wide > (IW+1)'(ENTRIES-1)))
      cnt_nxt = '0;
    else
      cnt_nxt = wide[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= cnt_nxt;
  end

  // R10: counter holds when no search happens
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
  // R10: reaching a nonzero boundary wraps to zero
  a_r10_wrap_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (limit != '0) && (cnt >= limit)) |=> (cnt == '0));
  // R10: without a boundary the counter steps by one below the top
  a_r10_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (limit == '0) && (cnt != IW'(ENTRIES-1))) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/xl_translate.sv
module xl_translate
  import xl_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [31:0]                req_addr,
  input  logic [1:0]                 req_kind,
  input  logic                       priv,
  input  logic [7:0]                 cur_asid,
  input  logic                       xlate_en,
  input  logic                       single_virt,
  input  logic [$clog2(ENTRIES)-1:0] rc_limit,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [21:0]                wr_vpn,
  input  logic [18:0]                wr_ppn,
  input  logic [7:0]                 wr_asid,
  input  logic                       wr_valid,
  input  logic                       wr_shared,
  input  logic                       wr_dirty,
  input  logic                       wr_cache,
  input  logic [1:0]                 wr_prot,
  input  logic [1:0]                 wr_size,
  output logic                       rsp_valid,
  output logic [31:0]                rsp_paddr,
  output logic [11:0]                rsp_fault,
  output logic                       rsp_cacheable,
  output logic [$clog2(ENTRIES)-1:0] repl_ctr,
  output logic [31:0]                fault_addr,
  output logic [21:0]                fault_vpn
);

  ent_t            wr_ent;
  logic            bypass, aerr, asid_chk, search;
  logic [VA_W-1:0] byp_addr, msk;
  logic            hit_any, hit_multi;
  hit_t            hit_fld;
  logic            is_wr;
  logic [FC_W-1:0] nxt_fault;
  logic [VA_W-1:0] nxt_paddr;
  logic            nxt_cach;

  assign wr_ent = '{vpn: wr_vpn, ppn: wr_ppn, asid: wr_asid, sh: wr_shared,
                    dirty: wr_dirty, cach: wr_cache, prot: wr_prot, sz: wr_size};

  assign asid_chk = !(single_virt && priv);
  assign is_wr    = (req_kind == ACC_WRITE);
  assign search   = req_valid && xlate_en && !bypass;

  xl_region u_region (
    .addr     (req_addr),
    .priv     (priv),
    .bypass   (bypass),
    .aerr     (aerr),
    .byp_addr (byp_addr)
  );

  xl_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_ent    (wr_ent),
    .wr_valid  (wr_valid),
    .lk_addr   (req_addr),
    .lk_asid   (cur_asid),
    .asid_chk  (asid_chk),
    .hit_any   (hit_any),
    .hit_multi (hit_multi),
    .hit_fld   (hit_fld)
  );

  xl_rr_ctr #(.ENTRIES(ENTRIES)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (search),
    .limit (rc_limit),
    .cnt   (repl_ctr)
  );

  assign msk = page_mask(hit_fld.sz);

  // Next-state: response decision with fixed priority.
  always_comb begin
    nxt_fault = F_NONE;
    nxt_paddr = '0;
    nxt_cach  = 1'b0;
    if (bypass) begin
      if (aerr) nxt_fault = is_wr ? F_AERR_WR : F_AERR_RD;
      else      nxt_paddr = byp_addr;
    end else if (!xlate_en) begin
      nxt_paddr = {3'b000, req_addr[PA_W-1:0]};
    end else if (hit_multi) begin
      nxt_fault = F_MULTI;
    end else if (!hit_any) begin
      nxt_fault = is_wr ? F_MISS_WR : F_MISS_RD;
    end else if (!priv && !hit_fld.prot[1]) begin
      nxt_fault = is_wr ? F_PROT_WR : F_PROT_RD;
    end else if (is_wr && !hit_fld.prot[0]) begin
      nxt_fault = F_PROT_WR;
    end else if (is_wr && !hit_fld.dirty) begin
      nxt_fault = F_INIT_WR;
    end else begin
      nxt_paddr = ({3'b000, hit_fld.ppn, {PG_SH{1'b0}}} & msk) | (req_addr & ~msk);
      nxt_cach  = hit_fld.cach;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_fault     <= '0;
      rsp_cacheable <= 1'b0;
      fault_addr    <= '0;
      fault_vpn     <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr     <= nxt_paddr;
        rsp_fault     <= nxt_fault;
        rsp_cacheable <= nxt_cach;
      end
      if (req_valid && (nxt_fault != F_NONE)) fault_addr <= req_addr;
      if (req_valid && (nxt_fault != F_NONE) && (nxt_fault != F_MULTI))
        fault_vpn <= req_addr[VA_W-1:PG_SH];
    end
  end

  // R12: response strobe follows the request by one clock
  a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R12: without a request the result registers hold
  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr)));
  // R12: a faulted response carries no address
  a_r12_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault != F_NONE)) |-> (rsp_paddr == '0));
  // R11: faulting address captured from the request
  a_r11_fault_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault != F_NONE)) |-> (fault_addr == $past(req_addr)));
  // R11: multiple-hit leaves the page number untouched
  a_r11_multi_keeps_vpn: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault == F_MULTI)) |-> (fault_vpn == $past(fault_vpn)));
  // R8: privileged accesses never get an address error
  a_r8_priv_no_aerr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv) |=> ((rsp_fault != F_AERR_RD) && (rsp_fault != F_AERR_WR)));

endmodule

// File: tb/tb_xl_translate.sv
`timescale 1ns/1ps
module tb_xl_translate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_kind;
  logic        priv;
  logic [7:0]  cur_asid;
  logic        xlate_en;
  logic        single_virt;
  logic [5:0]  rc_limit;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic [21:0] wr_vpn;
  logic [18:0] wr_ppn;
  logic [7:0]  wr_asid;
  logic        wr_valid, wr_shared, wr_dirty, wr_cache;
  logic [1:0]  wr_prot, wr_size;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [11:0] rsp_fault;
  logic        rsp_cacheable;
  logic [5:0]  repl_ctr;
  logic [31:0] fault_addr;
  logic [21:0] fault_vpn;

  always #2.5 clk = ~clk;

  xl_translate #(.ENTRIES(64)) dut (.*);

  // Reference state
  bit          m_v [64];
  bit [21:0]   m_vpn [64];
  bit [18:0]   m_ppn [64];
  bit [7:0]    m_asid [64];
  bit          m_sh [64], m_d [64], m_c [64];
  bit [1:0]    m_pr [64], m_sz [64];
  bit          e_valid;
  bit [31:0]   e_paddr, e_fa;
  bit [11:0]   e_fault;
  bit          e_cach;
  int          e_ctr;
  bit [21:0]   e_fv;
  string       tag;
  int          vectors = 0;
  int          errors  = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic longint pg_bytes(input bit [1:0] sz);
    case (sz)
      2'd0: return 64'd1024;
      2'd1: return 64'd4096;
      2'd2: return 64'd65536;
      default: return 64'd1048576;
    endcase
  endfunction

  task automatic model_eval();
    if (req_valid) begin
      bit p12, p4, wr, srch;
      longint a;
      int hits, idx;
      a    = longint'(req_addr);
      wr   = (req_kind == 2'd1);
      p12  = (a >= 64'h8000_0000) && (a < 64'hC000_0000);
      p4   = (a >= 64'hE000_0000);
      srch = 0;
      e_fault = 0; e_paddr = 0; e_cach = 0;
      if (p12 || p4) begin
        if (!priv && !(a >= 64'hE000_0000 && a < 64'hE400_0000))
          e_fault = wr ? 12'h100 : 12'h0E0;
        else
          e_paddr = p12 ? 32'(a % 64'h2000_0000) : req_addr;
      end else if (!xlate_en) begin
        e_paddr = 32'(a % 64'h2000_0000);
      end else begin
        srch = 1; hits = 0; idx = 0;
        for (int i = 0; i < 64; i++) begin
          longint sz, base;
          sz   = pg_bytes(m_sz[i]);
          base = longint'(m_vpn[i]) * 1024;
          base = base - (base % sz);
          if (m_v[i] && (m_sh[i] || (single_virt && priv) || m_asid[i] == cur_asid)
              && a >= base && a < base + sz) begin
            hits++; idx = i;
          end
        end
        if (hits > 1)                       e_fault = 12'h140;
        else if (hits == 0)                 e_fault = wr ? 12'h060 : 12'h040;
        else if (!priv && !m_pr[idx][1])    e_fault = wr ? 12'h0C0 : 12'h0A0;
        else if (wr && !m_pr[idx][0])       e_fault = 12'h0C0;
        else if (wr && !m_d[idx])           e_fault = 12'h080;
        else begin
          longint sz, pb;
          sz = pg_bytes(m_sz[idx]);
          pb = longint'(m_ppn[idx]) * 1024;
          e_paddr = 32'(pb - (pb % sz) + (a % sz));
          e_cach  = m_c[idx];
        end
      end
      if (srch) begin
        e_ctr++;
        if ((rc_limit != 0 && e_ctr > int'(rc_limit)) || e_ctr > 63) e_ctr = 0;
      end
      if (e_fault != 0) e_fa = req_addr;
      if (e_fault != 0 && e_fault != 12'h140) e_fv = req_addr[31:10];
      e_valid = 1;
    end else begin
      e_valid = 0;
    end
    if (wr_en) begin
      m_v[wr_idx] = wr_valid;     m_vpn[wr_idx] = wr_vpn;  m_ppn[wr_idx] = wr_ppn;
      m_asid[wr_idx] = wr_asid;   m_sh[wr_idx] = wr_shared; m_d[wr_idx] = wr_dirty;
      m_c[wr_idx] = wr_cache;     m_pr[wr_idx] = wr_prot;   m_sz[wr_idx] = wr_size;
    end
  endtask

  task automatic compare_all();
    chk("rsp_valid R12", 32'(rsp_valid), 32'(e_valid));
    chk("rsp_paddr R7", rsp_paddr, e_paddr);
    chk("rsp_fault R4", 32'(rsp_fault), 32'(e_fault));
    chk("rsp_cacheable R7", 32'(rsp_cacheable), 32'(e_cach));
    chk("repl_ctr R10", 32'(repl_ctr), 32'(e_ctr));
    chk("fault_addr R11", fault_addr, e_fa);
    chk("fault_vpn R11", 32'(fault_vpn), 32'(e_fv));
  endtask

  task automatic step();
    model_eval();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic load(input int idx, input bit [31:0] va, input bit [31:0] pa,
                      input bit [7:0] asid, input bit v, input bit sh, input bit d,
                      input bit c, input bit [1:0] pr, input bit [1:0] sz);
    tag = "load";
    wr_en = 1; wr_idx = 6'(idx); wr_vpn = va[31:10]; wr_ppn = pa[28:10];
    wr_asid = asid; wr_valid = v; wr_shared = sh; wr_dirty = d; wr_cache = c;
    wr_prot = pr; wr_size = sz;
    step();
    wr_en = 0;
  endtask

  task automatic rq(input bit [31:0] a, input bit [1:0] k, input bit pv,
                    input bit [7:0] asid, input string t);
    tag = t;
    req_valid = 1; req_addr = a; req_kind = k; priv = pv; cur_asid = asid;
    step();
    req_valid = 0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL R12 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_addr = 0; req_kind = 0; priv = 0; cur_asid = 0;
    xlate_en = 1; single_virt = 0; rc_limit = 0; wr_en = 0; wr_idx = 0; wr_vpn = 0;
    wr_ppn = 0; wr_asid = 0; wr_valid = 0; wr_shared = 0; wr_dirty = 0; wr_cache = 0;
    wr_prot = 0; wr_size = 0;
    e_valid = 0; e_paddr = 0; e_fa = 0; e_fault = 0; e_cach = 0; e_ctr = 0; e_fv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R12 reset";
    compare_all();

    // Table contents (R1 sizes, R2 tags, R5 protections, R6 dirty)
    load(0,  32'h0001_0000, 32'h0123_4000, 8'd5, 1, 0, 1, 1, 2'b11, 2'd1);
    load(1,  32'h0002_0000, 32'h0200_0400, 8'd5, 1, 0, 1, 0, 2'b10, 2'd0);
    load(2,  32'h0003_0000, 32'h0456_0000, 8'd5, 1, 0, 0, 1, 2'b11, 2'd2);
    load(3,  32'h0004_0000, 32'h0777_7000, 8'd5, 1, 0, 1, 0, 2'b01, 2'd1);
    load(4,  32'h0010_0000, 32'h1AB0_0000, 8'd9, 1, 1, 1, 1, 2'b11, 2'd3);
    load(5,  32'h0050_0000, 32'h0333_0C00, 8'd7, 1, 0, 1, 1, 2'b11, 2'd0);
    load(6,  32'h0060_0000, 32'h0500_0000, 8'd5, 1, 0, 1, 1, 2'b11, 2'd3);
    load(7,  32'h0064_0400, 32'h0600_0400, 8'd5, 1, 0, 1, 1, 2'b11, 2'd0);
    load(8,  32'h0070_0000, 32'h0700_0000, 8'd5, 0, 0, 1, 1, 2'b11, 2'd1);
    load(9,  32'h0008_1400, 32'h0099_9C00, 8'd5, 1, 0, 1, 1, 2'b11, 2'd1);

    rq(32'h0001_0ABC, 0, 0, 5, "R1 4K inside");
    rq(32'h0001_0FFF, 0, 0, 5, "R1 4K top");
    rq(32'h0001_1000, 0, 0, 5, "R1 4K past end");
    rq(32'h0002_03FF, 0, 0, 5, "R1 1K top");
    rq(32'h0002_0400, 0, 0, 5, "R1 1K past end");
    rq(32'h0003_FFF0, 0, 1, 5, "R1 64K");
    rq(32'h001F_FFFC, 0, 0, 5, "R1 1M top");
    rq(32'h0020_0000, 0, 0, 5, "R1 1M past end");
    rq(32'h0008_1000, 0, 0, 5, "R1 unaligned vpn");
    rq(32'h0050_0010, 0, 0, 5, "R2 tag mismatch");
    rq(32'h0050_0010, 0, 0, 7, "R2 tag match");
    rq(32'h0070_0010, 0, 1, 5, "R2 invalid entry");
    rq(32'h0012_3456, 2, 0, 3, "R2 shared entry");
    single_virt = 1;
    rq(32'h0050_0010, 0, 1, 5, "R3 priv single-virt");
    rq(32'h0050_0010, 0, 0, 5, "R3 user single-virt");
    single_virt = 0;
    rq(32'h0064_0410, 0, 1, 5, "R4 multi read");
    rq(32'h0064_0410, 1, 1, 5, "R4 multi write R11");
    rq(32'h0090_0000, 1, 1, 5, "R4 miss write");
    rq(32'h0090_0000, 2, 1, 5, "R4 miss fetch");
    rq(32'h0064_0410, 2, 0, 5, "R11 multi keeps vpn");
    rq(32'h0002_0010, 1, 0, 5, "R5 write readonly user");
    rq(32'h0002_0010, 1, 1, 5, "R5 write readonly priv");
    rq(32'h0004_0010, 0, 0, 5, "R5 user read priv-only");
    rq(32'h0004_0010, 2, 0, 5, "R5 user fetch priv-only");
    rq(32'h0004_0010, 1, 0, 5, "R5 user write priv-only");
    rq(32'h0004_0010, 1, 1, 5, "R5 priv write ok");
    rq(32'h0003_1234, 1, 0, 5, "R6 initial write");
    rq(32'h0003_1234, 0, 0, 5, "R6 read clean page");
    rq(32'h8000_1000, 0, 0, 5, "R8 user low window read");
    rq(32'hA000_0000, 1, 0, 5, "R8 user low window write");
    rq(32'hFF00_0000, 2, 0, 5, "R8 user top fetch");
    rq(32'hE000_1234, 1, 0, 5, "R8 user open window");
    rq(32'hE400_0000, 0, 0, 5, "R8 user past open window");
    rq(32'h9234_5678, 0, 1, 5, "R8 priv low window");
    rq(32'hBFFF_FFFF, 1, 1, 5, "R8 priv low window top");
    rq(32'hFC00_0000, 0, 1, 5, "R8 priv top passthrough");
    rq(32'hC000_0000, 0, 0, 5, "R8 user mid region translates");
    xlate_en = 0;
    rq(32'h7000_1234, 1, 0, 5, "R9 off low");
    rq(32'hC123_4567, 0, 0, 5, "R9 off mid");
    rq(32'h8000_0004, 0, 0, 5, "R9 off window still checked");
    xlate_en = 1;
    repeat (3) begin tag = "R12 idle hold"; step(); end
    rc_limit = 6'd3;
    for (int i = 0; i < 9; i++) rq(32'h0001_0000 + 32'(i), 0, 0, 5, "R10 limit wrap");
    rc_limit = 6'd0;
    for (int i = 0; i < 70; i++) rq(32'h0001_0000, 0, 0, 5, "R10 wrap at 63");

    // Random mix near the loaded pages
    for (int n = 0; n < 1500; n++) begin
      bit [31:0] bases [6];
      bases = '{32'h0001_0000, 32'h0002_0000, 32'h0003_0000, 32'h0010_0000,
                32'h0060_0000, 32'h8000_0000};
      wr_en = ($urandom_range(0, 15) == 0);
      if (wr_en) begin
        wr_idx = 6'($urandom_range(0, 15)); wr_vpn = 22'($urandom_range(0, 2047));
        wr_ppn = 19'($urandom); wr_asid = 8'($urandom_range(4, 6));
        {wr_valid, wr_shared, wr_dirty, wr_cache} = 4'($urandom);
        wr_prot = 2'($urandom); wr_size = 2'($urandom);
      end
      req_valid = ($urandom_range(0, 7) != 0);
      req_addr  = ($urandom_range(0, 3) == 0) ? $urandom
                : bases[$urandom_range(0, 5)] + 32'($urandom_range(0, 20'hFFFFF));
      req_kind  = 2'($urandom_range(0, 2));
      priv      = 1'($urandom);
      cur_asid  = 8'($urandom_range(4, 6));
      single_virt = ($urandom_range(0, 3) == 0);
      xlate_en  = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 31) == 0) rc_limit = 6'($urandom_range(0, 10));
      tag = "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random";
      step();
    end
    wr_en = 0; req_valid = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule